// File: doc/BRIEF.md
# Codec Command Slot Register Interface

This block lets software reach the control registers of an external audio codec through two outgoing slot registers and two incoming slot registers. Software first stores a data word in the slot-2 transmit register. It then writes the slot-1 transmit register with a register address and a direction bit. That second write starts one transaction on a small parallel codec port. The port carries a one-cycle strobe, a direction, a 7-bit address and 16-bit write data. Read results come back on a valid/data pair.

When a read completes, the incoming slot registers hold the response. Slot 1 holds the echoed command and slot 2 holds the returned data. A flag register shows three things: which transmit registers are still untouched since reset, whether a read is in flight, and whether a response is waiting to be collected. Bit-serial framing on the audio link is handled elsewhere.

Register select codes are: 0 slot-1 transmit, 1 slot-2 transmit, 2 slot-1 receive, 3 slot-2 receive, 4 flags. Any other code reads as zero. Flag bits are:
- bit0: slot-1 transmit empty
- bit1: slot-2 transmit empty
- bit2: both transmit registers empty
- bit3: slot-1 receive busy
- bit4: slot-2 receive busy
- bit5: slot-1 receive valid
- bit6: slot-2 receive valid

Top module: `codec_cmd_port`

## Requirements
- R1: After reset the flag register reads 0x07, both receive registers read 0, and the codec strobe is low.
- R2: A write to select 1 stores the whole word, which reads back unchanged. It clears flag bits 1 and 2 and produces no codec strobe.
- R3: A write to select 0 while no read is outstanding clears flag bits 0 and 2. It raises the codec strobe for exactly the cycle after the write.
- R4: During a strobe, the codec address equals bits 18:12 of the slot-1 transmit word and the direction equals its bit 19 (1 = read). The write data equals bits 19:4 of the slot-2 transmit word. All other bits of both words are ignored.
- R5: When a read completes, slot-1 receive holds the command word with bit 19 cleared. Slot-2 receive holds the returned 16-bit data shifted left by 4.
- R6: A read command sets flag bits 3 and 4 from the strobe cycle until the codec asserts read-valid. Completion then clears both bits and sets flag bits 5 and 6.
- R7: A write to select 0 while a read is outstanding is ignored. It produces no strobe and leaves the slot-1 transmit register unchanged.
- R8: Reading select 2 clears flag bit 5. Reading select 3 clears flag bit 6.
- R9: Codec read-valid is ignored while no read is outstanding. The receive registers and flags keep their values.
- R10: A write command (bit 19 = 0) sets neither the busy flags nor the valid flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect: clears valid flags) |
| sel | input | SEL_W | Register select code |
| wdata | input | REG_W | Register write data |
| rdata | output | REG_W | Register read data, combinational from sel |
| cc_stb | output | 1 | One-cycle codec transaction strobe |
| cc_read | output | 1 | Codec transaction direction, 1 = read |
| cc_addr | output | CA_W | Codec register address |
| cc_wdata | output | CD_W | Codec write data |
| cc_rvalid | input | 1 | Codec read data valid |
| cc_rdata | input | CD_W | Codec read data |

## Verification
The checker watches, on every cycle, that a strobe always follows a slot-1 write and never follows one made while a read was pending. It also checks that busy only rises together with a read strobe, that a completion clears busy and sets the valid flag with correctly shifted data, and that reading slot-1 receive drops its valid flag. Field extraction across all 128 codec addresses, the exact echoed command word, and the ignoring of stray read-valid pulses can only be shown by the bench's sweeps and scenarios. The bench compares each register readback against values it computes itself.

// File: rtl/codec_cmd_port.sv
module codec_cmd_port #(
  parameter int REG_W = 32,
  parameter int CA_W  = 7,
  parameter int CD_W  = 16,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [SEL_W-1:0] sel,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             cc_stb,
  output logic             cc_read,
  output logic [CA_W-1:0]  cc_addr,
  output logic [CD_W-1:0]  cc_wdata,
  input  logic             cc_rvalid,
  input  logic [CD_W-1:0]  cc_rdata
);
  localparam int DATA_LSB = 4;
  localparam int DIR_BIT  = DATA_LSB + CD_W - 1;
  localparam int ADDR_LSB = DIR_BIT - CA_W;
  localparam logic [SEL_W-1:0] SEL_CMD  = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_DAT  = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_RCMD = SEL_W'(2);
  localparam logic [SEL_W-1:0] SEL_RDAT = SEL_W'(3);
  localparam logic [SEL_W-1:0] SEL_FLG  = SEL_W'(4);
  localparam logic [REG_W-1:0] DIR_MASK = REG_W'(1) << DIR_BIT;

  logic [REG_W-1:0] cmd_q, dat_q, rsp_cmd_q, rsp_dat_q;
  logic s1_empty, s2_empty, busy, v1, v2, stb_q;

  wire launch = wr_en && sel == SEL_CMD && !busy;
  wire done   = busy && cc_rvalid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      dat_q     <= '0;
      rsp_cmd_q <= '0;
      rsp_dat_q <= '0;
      s1_empty  <= 1'b1;
      s2_empty  <= 1'b1;
      busy      <= 1'b0;
      v1        <= 1'b0;
      v2        <= 1'b0;
      stb_q     <= 1'b0;
    end else begin
      stb_q <= launch;
      if (launch) begin
        cmd_q    <= wdata;
        s1_empty <= 1'b0;
        busy     <= wdata[DIR_BIT];
      end
      if (wr_en && sel == SEL_DAT) begin
        dat_q    <= wdata;
        s2_empty <= 1'b0;
      end
      if (rd_en && sel == SEL_RCMD) v1 <= 1'b0;
      if (rd_en && sel == SEL_RDAT) v2 <= 1'b0;
      if (done) begin
        rsp_cmd_q <= cmd_q & ~DIR_MASK;
        rsp_dat_q <= REG_W'(cc_rdata) << DATA_LSB;
        busy      <= 1'b0;
        v1        <= 1'b1;
        v2        <= 1'b1;
      end
    end
  end

  assign cc_stb   = stb_q;
  assign cc_read  = cmd_q[DIR_BIT];
  assign cc_addr  = cmd_q[DIR_BIT-1:ADDR_LSB];
  assign cc_wdata = dat_q[DIR_BIT:DATA_LSB];

  wire [6:0] flags = {v2, v1, busy, busy, s1_empty & s2_empty, s2_empty, s1_empty};

  always_comb begin
    case (sel)
      SEL_CMD:  rdata = cmd_q;
      SEL_DAT:  rdata = dat_q;
      SEL_RCMD: rdata = rsp_cmd_q;
      SEL_RDAT: rdata = rsp_dat_q;
      SEL_FLG:  rdata = REG_W'(flags);
      default:  rdata = '0;
    endcase
  end
endmodule

module codec_cmd_port_chk #(
  parameter int REG_W = 32,
  parameter int CD_W  = 16,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [SEL_W-1:0] sel,
  input logic             cc_stb,
  input logic             cc_read,
  input logic             cc_rvalid,
  input logic [CD_W-1:0]  cc_rdata,
  input logic             busy,
  input logic             v1,
  input logic [REG_W-1:0] rsp_dat_q
);
  p_stb_after_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cc_stb |-> $past(wr_en && sel == SEL_W'(0)));

  p_no_launch_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cc_stb |-> !$past(busy));

  p_busy_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cc_stb && cc_read);

  p_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cc_rvalid |=> !busy && v1);

  p_rx2_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cc_rvalid |=> rsp_dat_q == (REG_W'($past(cc_rdata)) << 4));

  p_rd_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && sel == SEL_W'(2) && !(busy && cc_rvalid) |=> !v1);
endmodule

bind codec_cmd_port codec_cmd_port_chk #(.REG_W(REG_W), .CD_W(CD_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .sel(sel),
  .cc_stb(cc_stb), .cc_read(cc_read), .cc_rvalid(cc_rvalid), .cc_rdata(cc_rdata),
  .busy(busy), .v1(v1), .rsp_dat_q(rsp_dat_q)
);

// File: tb/codec_cmd_port_tb.sv
module codec_cmd_port_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  sel = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cc_stb, cc_read;
  logic [6:0]  cc_addr;
  logic [15:0] cc_wdata;
  logic        cc_rvalid = 1'b0;
  logic [15:0] cc_rdata = '0;

  int n_tests = 0, n_fail = 0;
  logic [15:0] model [128];

  always #(CLK_P/2) clk = ~clk;

  codec_cmd_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .sel(sel),
    .wdata(wdata), .rdata(rdata), .cc_stb(cc_stb), .cc_read(cc_read),
    .cc_addr(cc_addr), .cc_wdata(cc_wdata), .cc_rvalid(cc_rvalid), .cc_rdata(cc_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; sel = s;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic respond(input logic [15:0] d);
    @(negedge clk);
    cc_rvalid = 1'b1; cc_rdata = d;
    @(negedge clk);
    cc_rvalid = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r, cmd, dw;
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(3'd4, r); chk("R1 flags", r, 32'h07);
    bus_read(3'd2, r); chk("R1 rx1", r, 0);
    bus_read(3'd3, r); chk("R1 rx2", r, 0);
    chk("R1 stb", {31'b0, cc_stb}, 0);

    // R2 slot-2 write only latches
    bus_write(3'd1, 32'hDEAD_BEEF);
    chk("R2 no stb", {31'b0, cc_stb}, 0);
    bus_read(3'd1, r); chk("R2 readback", r, 32'hDEAD_BEEF);
    bus_read(3'd4, r); chk("R2 flags", r, 32'h01);

    // R3/R4/R10 write sweep over all addresses
    for (int a = 0; a < 128; a++) begin
      d = 16'((a * 613 + 17) & 16'hFFFF);
      dw = 32'hABC0_0000 | (32'(d) << 4) | 32'(a & 15);
      cmd = 32'h7F00_0000 | (32'(a) << 12) | 32'((a * 7) & 12'hFFF);
      bus_write(3'd1, dw);
      bus_write(3'd0, cmd);
      chk("R3 stb", {31'b0, cc_stb}, 1);
      chk("R4 dir", {31'b0, cc_read}, 0);
      chk("R4 addr", {25'b0, cc_addr}, 32'(a));
      chk("R4 wdata", {16'b0, cc_wdata}, {16'b0, d});
      model[a] = d;
      @(negedge clk);
      chk("R3 stb one cycle", {31'b0, cc_stb}, 0);
    end
    bus_read(3'd4, r); chk("R10 flags after writes", r, 32'h00);

    // R5..R8 read sweep
    for (int a = 0; a < 128; a += 5) begin
      cmd = 32'hC008_0000 | (32'(a) << 12) | 32'((a * 3) & 12'hFFF);
      bus_write(3'd0, cmd);
      chk("R3 read stb", {31'b0, cc_stb}, 1);
      chk("R4 read dir", {31'b0, cc_read}, 1);
      chk("R4 read addr", {25'b0, cc_addr}, 32'(a));
      bus_read(3'd4, r); chk("R6 busy flags", r, 32'h18);
      bus_write(3'd0, 32'h0001_2000);
      chk("R7 no stb when busy", {31'b0, cc_stb}, 0);
      for (int k = 0; k < a % 4; k++) @(negedge clk);
      respond(model[a]);
      bus_read(3'd4, r); chk("R6 valid flags", r, 32'h60);
      bus_read(3'd2, r); chk("R5 rx1 echo", r, cmd & ~32'h0008_0000);
      bus_read(3'd4, r); chk("R8 rx1 read clears", r, 32'h40);
      bus_read(3'd3, r); chk("R5 rx2 data", r, 32'(model[a]) << 4);
      bus_read(3'd4, r); chk("R8 rx2 read clears", r, 32'h00);
      bus_read(3'd0, r); chk("R7 cmd unchanged", r, cmd);
    end

    // R9 stray response ignored
    respond(16'h1234);
    bus_read(3'd4, r); chk("R9 flags", r, 32'h00);
    bus_read(3'd3, r); chk("R9 rx2", r, 32'(model[125]) << 4);
    bus_read(3'd2, r); chk("R9 rx1", r, (32'hC008_0000 | (32'd125 << 12) | 32'd375) & ~32'h0008_0000);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule